// File: doc/BRIEF.md
# Serial Delay-Code Configuration Loader

This block takes configuration words from a slow three-wire serial port (serial clock, serial data, load strobe) and turns them into two delay codes plus one shared path-mode bit. The codes and mode bit drive a pair of programmable delay channels. The three pins are brought into a faster system clock through synchronisers. All shifting and latching then happens on system-clock edges.

Each word is eleven bits long. The first bit sent picks the target channel. The second bit picks the path mode: either two independent paths, or one cascaded path. The last nine bits carry the delay code, least significant bit first. While the strobe is high, the selected channel's code follows the shift register. When the strobe falls, the code is frozen. Setting both channels therefore takes two full load cycles.

The system clock must run at least four times faster than the serial clock. This lets every serial level be seen for two or more system cycles after synchronisation.

Top module: `dly_cfg_loader`

## Requirements
- R1: The shift register advances by exactly one position for each rising edge of `ser_clk_i`, taking the `ser_dat_i` level into its top bit. Without such an edge it does not change.
- R2: After eleven shifts, the first bit sent sits in bit 0 and selects the target: 0 loads `code0_o` and 1 loads `code1_o`. Bits sent before the last eleven have no effect.
- R3: Bit 1 (the second bit sent) becomes `cascade_o`: 0 means independent paths, 1 means cascaded. Bits 2 to 10 are the delay code, with the third bit sent as the code LSB and the last bit sent as the code MSB.
- R4: While `ser_ld_i` is high, the selected output follows the shift register, including shifts made while the strobe stays high.
- R5: After `ser_ld_i` falls, no activity on `ser_clk_i` or `ser_dat_i` changes `code0_o`, `code1_o` or `cascade_o`.
- R6: A load writes only the selected channel. The other channel's code keeps its value.
- R7: Reset clears both codes and `cascade_o` to zero.
- R8: `cascade_o` takes its value from the most recent load, whichever channel that load targeted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, sampled on serial clock rise |
| ser_ld_i | input | 1 | Load strobe: transparent while high, holds on fall |
| code0_o | output | CODE_W | Delay code for channel 0 |
| code1_o | output | CODE_W | Delay code for channel 1 |
| cascade_o | output | 1 | Path mode: 0 independent, 1 cascaded |

## Verification
The checker watches the synchronised strobe and the shift register on every cycle. It confirms that the register moves one place per detected serial edge and stays put otherwise. It also confirms that the outputs are frozen while the strobe is low, that a load never touches the channel it did not select, and that a selected output mirrors the register while the strobe is high. Some properties depend on the whole path from pins to outputs, and only the bench scenarios can show them. These include the bit order of a complete word, discarding extra leading bits, mode-bit ownership across channels, and the reset values.

// File: rtl/dlyc_pkg.sv
package dlyc_pkg;
   // word layout in the shift register after a full cycle
   localparam int unsigned SEL_POS  = 0;
   localparam int unsigned MODE_POS = 1;
   localparam int unsigned HDR_BITS = 2;
   localparam int unsigned NUM_CH   = 2;

   typedef enum logic {
      PATH_SPLIT   = 1'b0,
      PATH_CASCADE = 1'b1
   } path_mode_e;
endpackage

// File: rtl/dlyc_sync.sv
module dlyc_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dlyc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dlyc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dlyc_shifter.sv
module dlyc_shifter #(
   parameter int unsigned SHIFT_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdat_s,
   output logic               shift_pulse,
   output logic [SHIFT_W-1:0] sr_q
);
   if (SHIFT_W < 3) begin : g_bad_w
      $error("dlyc_shifter: SHIFT_W too small");
   end

   logic sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign shift_pulse = sclk_s & ~sclk_d;

   // new bit enters at the top, so the first bit sent ends at bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sr_q <= '0;
      else if (shift_pulse) sr_q <= {sdat_s, sr_q[SHIFT_W-1:1]};
   end
endmodule

// File: rtl/dlyc_latch_bank.sv
module dlyc_latch_bank
   import dlyc_pkg::*;
#(
   parameter int unsigned CODE_W  = 9,
   localparam int unsigned SHIFT_W = CODE_W + HDR_BITS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_s,
   input  logic [SHIFT_W-1:0]            word_i,
   output logic [NUM_CH-1:0][CODE_W-1:0] code_o,
   output path_mode_e                    mode_o
);
   logic sel;
   assign sel = word_i[SEL_POS];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_o[ch] <= '0;
         else if (ld_s && (sel == ch[0]))
            code_o[ch] <= word_i[SHIFT_W-1:HDR_BITS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_o <= PATH_SPLIT;
      else if (ld_s) mode_o <= path_mode_e'(word_i[MODE_POS]);
   end
endmodule

// File: rtl/dly_cfg_loader.sv
module dly_cfg_loader
   import dlyc_pkg::*;
#(
   parameter int unsigned CODE_W      = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              ser_ld_i,
   output logic [CODE_W-1:0] code0_o,
   output logic [CODE_W-1:0] code1_o,
   output logic              cascade_o
);
   localparam int unsigned SHIFT_W = CODE_W + HDR_BITS;

   logic [2:0]                    pins_s;
   logic                          sclk_s, sdat_s, ld_s;
   logic                          shift_pulse;
   logic [SHIFT_W-1:0]            sr_q;
   logic [NUM_CH-1:0][CODE_W-1:0] codes;
   path_mode_e                    mode;

   dlyc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_ld_i, ser_dat_i, ser_clk_i}),
      .sync_o  (pins_s)
   );

   assign sclk_s = pins_s[0];
   assign sdat_s = pins_s[1];
   assign ld_s   = pins_s[2];

   dlyc_shifter #(.SHIFT_W(SHIFT_W)) shift_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (sclk_s),
      .sdat_s      (sdat_s),
      .shift_pulse (shift_pulse),
      .sr_q        (sr_q)
   );

   dlyc_latch_bank #(.CODE_W(CODE_W)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_s   (ld_s),
      .word_i (sr_q),
      .code_o (codes),
      .mode_o (mode)
   );

   assign code0_o   = codes[0];
   assign code1_o   = codes[1];
   assign cascade_o = (mode == PATH_CASCADE);
endmodule

// File: rtl/dlyc_chk.sv
module dlyc_chk #(
   parameter int unsigned CODE_W  = 9,
   localparam int unsigned SHIFT_W = CODE_W + 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_s,
   input logic               shift_pulse,
   input logic [SHIFT_W-1:0] sr_q,
   input logic [CODE_W-1:0]  code0,
   input logic [CODE_W-1:0]  code1,
   input logic               casc
);
   assert_one_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> sr_q[SHIFT_W-2:0] == $past(sr_q[SHIFT_W-1:1]));

   assert_no_spurious_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_pulse |=> $stable(sr_q));

   assert_track_ch0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && !sr_q[0]) |=> code0 == $past(sr_q[SHIFT_W-1:2]));

   assert_track_ch1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && sr_q[0]) |=> code1 == $past(sr_q[SHIFT_W-1:2]));

   assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_s |=> ($stable(code0) && $stable(code1) && $stable(casc)));

   assert_ch1_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && !sr_q[0]) |=> $stable(code1));

   assert_ch0_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && sr_q[0]) |=> $stable(code0));

   assert_mode_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_s |=> casc == $past(sr_q[1]));
endmodule

bind dly_cfg_loader dlyc_chk #(.CODE_W(CODE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_s        (ld_s),
   .shift_pulse (shift_pulse),
   .sr_q        (sr_q),
   .code0       (code0_o),
   .code1       (code1_o),
   .casc        (cascade_o)
);

// File: tb/dly_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module dly_cfg_loader_tb_top;
   localparam int CW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
   logic [CW-1:0] code0, code1;
   logic casc;

   always #2 clk = ~clk;   // 250 MHz

   dly_cfg_loader #(.CODE_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
      .code0_o(code0), .code1_o(code1), .cascade_o(casc)
   );

   typedef struct {
      logic [CW-1:0] c0;
      logic [CW-1:0] c1;
      logic          m;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model of the word, from the requirements
   logic [CW+1:0] m_sr = '0;
   logic [CW-1:0] m_c0 = '0, m_c1 = '0;
   logic m_mode = 1'b0;
   logic m_ld = 1'b0;

   function automatic void m_apply();
      if (m_sr[0]) m_c1 = m_sr[CW+1:2];
      else         m_c0 = m_sr[CW+1:2];
      m_mode = m_sr[1];
   endfunction

   task automatic expect_now(input string tag);
      exp_t e;
      e.c0 = m_c0; e.c1 = m_c1; e.m = m_mode; e.tag = tag;
      exp_q.push_back(e);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops expectations and compares away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (code0 !== e.c0 || code1 !== e.c1 || casc !== e.m) begin
               bad++;
               $display("FAIL %s: actual c0=%h c1=%h casc=%b expected c0=%h c1=%h casc=%b",
                        e.tag, code0, code1, casc, e.c0, e.c1, e.m);
            end
         end
      end
   end

   task automatic send_bit(input logic b);
      @(negedge clk); sdat = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      m_sr = {b, m_sr[CW+1:1]};
      if (m_ld) m_apply();
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // word: sel first, then mode, then code LSB first
   task automatic send_word(input logic sel, input logic mode, input logic [CW-1:0] code);
      send_bit(sel);
      send_bit(mode);
      for (int i = 0; i < CW; i++) send_bit(code[i]);
   endtask

   task automatic strobe_hi();
      @(negedge clk); sld = 1'b1; m_ld = 1'b1; m_apply();
      repeat (8) @(negedge clk);
   endtask

   task automatic strobe_lo();
      @(negedge clk); sld = 1'b0; m_ld = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic load(input logic sel, input logic mode, input logic [CW-1:0] code);
      send_word(sel, mode, code);
      strobe_hi();
      strobe_lo();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      expect_now("R7 reset state");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_now("R7 after reset release");

      load(1'b0, 1'b0, 9'h155);
      expect_now("R2 R3 ch0 load 0x155 split");

      load(1'b1, 1'b0, 9'h0AA);
      expect_now("R6 ch1 load keeps ch0");

      load(1'b0, 1'b1, 9'h1FF);
      expect_now("R3 R8 ch0 all-ones cascade");

      load(1'b1, 1'b0, 9'h001);
      expect_now("R8 ch1 load clears cascade");

      // R2 extra leading bits are discarded
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      load(1'b0, 1'b0, 9'h100);
      expect_now("R2 leading extra bits ignored, code MSB only");

      // R5 activity after strobe fall
      for (int i = 0; i < 7; i++) send_bit(i[0]);
      expect_now("R5 hold after strobe fall");
      repeat (4) @(negedge clk); sdat = 1'b1;
      repeat (10) @(negedge clk);
      expect_now("R5 data toggling without clock");

      // R4 transparency: strobe high, then shift more bits
      send_word(1'b1, 1'b1, 9'h0F0);
      strobe_hi();
      expect_now("R4 transparent on strobe rise");
      send_bit(1'b0);
      expect_now("R4 follows shift while strobe high (1)");
      send_bit(1'b1);
      expect_now("R4 follows shift while strobe high (2)");
      strobe_lo();
      expect_now("R4 R5 frozen at strobe fall");

      load(1'b1, 1'b0, 9'h000);
      expect_now("R3 ch1 zero code split");

      // R1 single shift: one clock pulse moves word by one place
      send_word(1'b0, 1'b1, 9'h0C3);
      send_bit(1'b0);
      strobe_hi(); strobe_lo();
      expect_now("R1 one extra shift changes target");

      // R7 reset mid-use
      @(negedge clk); rst_n = 1'b0;
      m_c0 = '0; m_c1 = '0; m_mode = 1'b0; m_sr = '0;
      repeat (3) @(negedge clk);
      expect_now("R7 reset clears loaded values");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog (all R): actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule